// File: doc/BRIEF.md
# Open-Page DRAM Read Sequencer

This block drives the command bus of one synchronous DRAM bank for read traffic only. It takes read requests made of a row address, a column address and a burst-length code over a valid/ready handshake. For each request it emits the shortest legal series of precharge, activate and column-read commands. It remembers the row held in the sense amplifiers. A request that hits that row costs one column read. A request that misses it first closes the row, then opens the new one, then reads.

Three countdown timers hold the commands apart. One covers the activate-to-read delay, one covers the precharge recovery time and one keeps bursts from overlapping. A read pipeline of CAS-latency depth tracks each read in flight. It opens a capture window when the bank's data arrives and registers each beat with a valid strobe. The same pipeline tells the controller when a precharge is safe, because the sense amplifiers must not be disturbed while their data is still leaving the chip.

Top module: `dram_rd_seq`

## Requirements
- R1: Out of reset the command output is NOP (code 0), `req_ready` is high, `rd_valid` is low and the bank counts as closed, so the first request produces an activate and then a read with no precharge.
- R2: Command codes are NOP=0, ACT=1, READ=2, PRE=3. A READ appears only while a row is open, and it targets the row that the most recent ACT put on `cmd_row`.
- R3: A READ comes at least TRCD cycles after the ACT that opened its row.
- R4: An ACT comes at least TRP cycles after the preceding PRE.
- R5: A request whose row equals the open row produces exactly one READ carrying the requested column on `cmd_col`, with no PRE or ACT before it.
- R6: A request to a different row produces PRE, then ACT with the new row, then READ, in that order.
- R7: A PRE never appears in a cycle at or before the cycle in which the last data beat of an earlier read is on `dq_in`.
- R8: For a READ visible in cycle c, beat k is sampled from `dq_in` in cycle c+CL+k and shown on `rd_data` with `rd_valid` high in cycle c+CL+k+1. The beats arrive in column order from the requested column, wrapping modulo 2^COL_W.
- R9: The burst code `req_burst` selects 0→1, 1→2, 2→4, 3→8 beats, and `rd_valid` is high for exactly that many consecutive cycles per read.
- R10: Two READs are at least as many cycles apart as the first one's burst length, so the data windows never overlap. A hit may still issue while the previous burst is transferring.
- R11: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low in every cycle that shows a PRE or ACT of a row-miss or first-open sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Starting column of the request |
| req_burst | input | 2 | Burst-length code (1/2/4/8 beats) |
| cmd_code | output | 2 | Command to the bank: NOP, ACT, READ, PRE |
| cmd_row | output | ROW_W | Row address carried by ACT, zero otherwise |
| cmd_col | output | COL_W | Column address carried by READ, zero otherwise |
| dq_in | input | DQ_W | Data bus from the bank |
| rd_data | output | DQ_W | Captured read beat |
| rd_valid | output | 1 | `rd_data` holds a beat this cycle |

## Verification
The bench builds the block with an 8-bit row, a 6-bit column, a 16-bit data bus, TRCD=3, TRP=4 and CL=3. The unequal TRCD and TRP mean that swapping the two timers is caught. The narrow column field lets an 8-beat burst starting at column 60 wrap through zero. With TRCD=3 a page hit can be issued while a long burst is still on the bus. A miss that follows a long burst makes the precharge wait for the data window to close.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } dram_cmd_e;

  // Index of the last beat of a burst: code 0..3 -> 1,2,4,8 beats
  function automatic logic [2:0] burst_last(input logic [1:0] code);
    logic [3:0] beats;
    beats = 4'd1 << code;
    return 3'(beats - 4'd1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/drs_gap_timer.sv
module drs_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // a fresh load must be visible on the next cycle before counting down
  assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/drs_read_pipe.sv
module drs_read_pipe #(
  parameter int CL   = 3,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [2:0]      last_idx,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid,
  output logic            bank_busy,
  output logic            inflight
);
  logic [CL:0] pipe_v;
  logic [2:0]  pipe_l [0:CL];
  logic [2:0]  rem;
  logic        beat_start;
  logic        cap_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v <= '0;
      for (int i = 0; i <= CL; i++) pipe_l[i] <= '0;
    end else begin
      pipe_v <= {pipe_v[CL-1:0], issue};
      pipe_l[0] <= last_idx;
      for (int i = 1; i <= CL; i++) pipe_l[i] <= pipe_l[i-1];
    end
  end

  assign beat_start = pipe_v[CL];
  assign cap_now    = beat_start || (rem != 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)            rem <= '0;
    else if (beat_start)   rem <= pipe_l[CL];
    else if (rem != 3'd0)  rem <= rem - 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_now;
      if (cap_now) rd_data <= dq_in;
    end
  end

  // busy: some beat still lies beyond the next cycle
  assign bank_busy = (|pipe_v) || (rem > 3'd1);
  assign inflight  = (|pipe_v) || (rem != 3'd0);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |-> (rem == 3'd0));
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |=> rd_valid);

endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq
  import dram_rd_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int DQ_W  = 16,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int CL    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [1:0]       req_burst,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  rd_data,
  output logic             rd_valid
);
  localparam int unsigned TMAX = max3(TRCD, TRP, 8);
  localparam int TW = $clog2(TMAX + 1);
  localparam int SW = TW + 2;

  // held request
  logic             hold_v;
  logic [ROW_W-1:0] hold_row;
  logic [COL_W-1:0] hold_col;
  logic [2:0]       hold_last;

  // bank state
  logic             row_open;
  logic [ROW_W-1:0] open_row;

  // named internal events
  logic row_hit, rd_fire, pre_fire, act_fire, accept;
  logic rcd_ok, rp_ok, ccd_ok;
  logic bank_busy, inflight;
  dram_cmd_e cmd_q;

  assign row_hit   = row_open && (hold_row == open_row);
  assign rd_fire   = hold_v && row_hit && rcd_ok && ccd_ok;
  assign pre_fire  = hold_v && row_open && !row_hit && !bank_busy;
  assign act_fire  = hold_v && !row_open && rp_ok;
  assign req_ready = !hold_v || rd_fire;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_row  <= '0;
      hold_col  <= '0;
      hold_last <= '0;
    end else begin
      if (accept) begin
        hold_v    <= 1'b1;
        hold_row  <= req_row;
        hold_col  <= req_col;
        hold_last <= burst_last(req_burst);
      end else if (rd_fire) begin
        hold_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (act_fire) begin
      row_open <= 1'b1;
      open_row <= hold_row;
    end else if (pre_fire) begin
      row_open <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NOP;
      cmd_row <= '0;
      cmd_col <= '0;
    end else begin
      cmd_q   <= CMD_NOP;
      cmd_row <= '0;
      cmd_col <= '0;
      if (rd_fire) begin
        cmd_q   <= CMD_RD;
        cmd_col <= hold_col;
      end else if (act_fire) begin
        cmd_q   <= CMD_ACT;
        cmd_row <= hold_row;
      end else if (pre_fire) begin
        cmd_q   <= CMD_PRE;
      end
    end
  end

  assign cmd_code = cmd_q;

  drs_gap_timer #(.W(TW)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_fire),
    .load_val(TW'(TRCD - 1)), .expired(rcd_ok));

  drs_gap_timer #(.W(TW)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(pre_fire),
    .load_val(TW'(TRP - 1)), .expired(rp_ok));

  drs_gap_timer #(.W(TW)) u_ccd (
    .clk(clk), .rst_n(rst_n), .load(rd_fire),
    .load_val(TW'(hold_last)), .expired(ccd_ok));

  drs_read_pipe #(.CL(CL), .DQ_W(DQ_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .issue(rd_fire), .last_idx(hold_last),
    .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .bank_busy(bank_busy), .inflight(inflight));

  // cycle distance from the last ACT and PRE seen on the command output
  logic [SW-1:0] since_act, since_pre;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0;
      since_pre <= '1;
    end else begin
      if (cmd_q == CMD_ACT)   since_act <= SW'(1);
      else if (since_act != '1) since_act <= since_act + 1'b1;
      if (cmd_q == CMD_PRE)   since_pre <= SW'(1);
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
    end
  end

  assert_read_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> row_open);
  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> (since_act >= SW'(TRCD)));
  assert_rp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> (since_pre >= SW'(TRP)));
  assert_pre_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> !inflight);
  assert_ready_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_PRE) || (cmd_q == CMD_ACT)) |-> !req_ready);

endmodule

// File: tb/tb_dram_rd_seq.sv
module tb_dram_rd_seq;
  localparam int ROW_W = 8;
  localparam int COL_W = 6;
  localparam int DQ_W  = 16;
  localparam int TRCD  = 3;
  localparam int TRP   = 4;
  localparam int CL    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0] req_burst = '0;
  logic [1:0] cmd_code;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [DQ_W-1:0] dq = '0;
  logic [DQ_W-1:0] rd_data;
  logic rd_valid;

  always #4 clk = ~clk;

  dram_rd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
                .TRCD(TRCD), .TRP(TRP), .CL(CL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_burst(req_burst),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .dq_in(dq), .rd_data(rd_data), .rd_valid(rd_valid));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int row; int col; int sel; int kind; } req_t;   // kind 0 first,1 hit,2 miss
  typedef struct { int t; logic [DQ_W-1:0] d; } beat_t;
  req_t  req_q[$];
  beat_t beat_q[$];
  logic [DQ_W-1:0] exp_q[$];
  int due_q[$];

  function automatic logic [DQ_W-1:0] beat_val(input int row, input int col);
    logic [7:0] r;
    logic [5:0] c;
    r = 8'(row);
    c = 6'(col);
    return {r, 2'b10, c};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bank model and command checker
  bit m_open = 1'b0;
  int m_row = 0;
  int last_act = -1000, last_pre = -1000, last_rd = -1000, last_n = 0;
  int last_beat = -1;
  int n_pre = 0, n_act = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_q.size() > 0 && beat_q[0].t == cyc) begin
        dq = beat_q[0].d;
        void'(beat_q.pop_front());
      end else dq = '0;
      if (cmd_code == 2'd3) begin
        chk(m_open, "R6 PRE on open bank", m_open, 1);
        chk(cyc > last_beat, "R7 PRE after last beat", cyc, last_beat + 1);
        chk(!req_ready, "R11 ready low at PRE", req_ready, 0);
        m_open = 1'b0; last_pre = cyc; n_pre++;
      end else if (cmd_code == 2'd1) begin
        chk(!m_open, "R6 ACT on closed bank", m_open, 0);
        chk(cyc - last_pre >= TRP, "R4 PRE to ACT gap", cyc - last_pre, TRP);
        chk(!req_ready, "R11 ready low at ACT", req_ready, 0);
        m_open = 1'b1; m_row = int'(cmd_row); last_act = cyc; n_act++;
      end else if (cmd_code == 2'd2) begin
        req_t r;
        int n;
        chk(m_open, "R2 READ on open row", m_open, 1);
        chk(cyc - last_act >= TRCD, "R3 ACT to READ gap", cyc - last_act, TRCD);
        chk(cyc - last_rd >= last_n, "R10 READ spacing", cyc - last_rd, last_n);
        if (req_q.size() == 0) chk(1'b0, "R2 unexpected READ", 1, 0);
        else begin
          r = req_q.pop_front();
          chk(m_row == r.row, "R2 READ row", m_row, r.row);
          chk(int'(cmd_col) == r.col, "R5 READ column", int'(cmd_col), r.col);
          if (r.kind == 0) begin
            chk(n_pre == 0 && n_act == 1, "R1 first request opens directly", n_pre*10+n_act, 1);
          end else if (r.kind == 1) begin
            chk(n_pre == 0 && n_act == 0, "R5 hit issues READ only", n_pre*10+n_act, 0);
          end else begin
            chk(n_pre == 1 && n_act == 1, "R6 miss issues PRE and ACT", n_pre*10+n_act, 11);
          end
          n = 1 << r.sel;
          for (int k = 0; k < n; k++) begin
            beat_t b;
            b.t = cyc + CL + k;
            b.d = beat_val(m_row, (r.col + k) % 64);
            beat_q.push_back(b);
            due_q.push_back(cyc + CL + k + 1);
          end
          last_beat = cyc + CL + n - 1;
          last_rd = cyc; last_n = n;
        end
        n_pre = 0; n_act = 0;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (due_q.size() == 0 || exp_q.size() == 0) chk(1'b0, "R9 extra valid beat", 1, 0);
        else begin
          int due;
          logic [DQ_W-1:0] e;
          due = due_q.pop_front();
          e = exp_q.pop_front();
          chk(due == cyc, "R8 beat timing", cyc, due);
          chk(rd_data == e, "R8 beat data", int'(rd_data), int'(e));
        end
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        chk(1'b0, "R9 missing valid beat", 0, 1);
        void'(due_q.pop_front());
      end
    end
  end

  int drv_row = -1;

  task automatic send(input int row, input int col, input int sel);
    req_t r;
    @(negedge clk);
    req_valid = 1'b1;
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    req_burst = 2'(sel);
    while (!req_ready) @(negedge clk);
    r.row = row; r.col = col; r.sel = sel;
    r.kind = (drv_row < 0) ? 0 : ((drv_row == row) ? 1 : 2);
    drv_row = row;
    req_q.push_back(r);
    for (int k = 0; k < (1 << sel); k++) exp_q.push_back(beat_val(row, (col + k) % 64));
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == 2'd0, "R1 reset command NOP", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1 reset ready high", req_ready, 1);
    chk(rd_valid == 1'b0, "R1 reset no valid", rd_valid, 0);
    send(5, 0, 2);       // first open, 4 beats
    send(5, 10, 3);      // hit overlapping burst
    send(5, 60, 3);      // hit with column wrap
    send(9, 3, 0);       // miss after long burst
    send(9, 7, 1);       // hit
    send(2, 20, 3);      // miss
    send(5, 1, 0);       // miss straight after
    send(5, 2, 0);       // hits of 1 and 2 beats
    send(5, 4, 1);
    for (int i = 0; i < 20; i++) send((i / 3) % 4, (i * 7) % 64, i % 4);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9 all beats delivered", exp_q.size(), 0);
    chk(req_q.size() == 0, "R5 all requests read", req_q.size(), 0);
    chk(rd_valid == 1'b0, "R9 valid drops when idle", rd_valid, 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule